// File: doc/BRIEF.md
# Interrupt Mode Routing Register

This block is a small I/O-mapped control register that chooses how two legacy interrupt lines reach the bootstrap processor. The two lines are the legacy controller's interrupt request output and the non-maskable interrupt line. Software reaches the register indirectly. It first writes a fixed select code to an index port. It then writes or reads the register through a neighbouring data port.

The register holds a single routing bit. When the bit is clear, the two lines drive the processor's own interrupt pins directly. When the bit is set, the lines go to the two local-interrupt inputs of the local interrupt controller instead, and the direct pins are held low. All four steered outputs come from flip-flops. A change of routing therefore shows up cleanly on one clock edge.

The index port and the data port addresses are parameters, and so is the select code. Any data-port access made while the index latch holds another code is ignored.

Top module: `intr_route_ctl`

## Requirements
- R1: After reset the routing bit is 0 and the index latch holds 00h. With both interrupt inputs low, all four steered outputs are 0.
- R2: A write to the index port (default 22h) with the value 70h selects the routing register. A following data-port (default 23h) write then loads bit 0 of the written byte into the routing bit.
- R3: Only data bit 0 is stored. A data-port read with the register selected returns 0000000b followed by the routing bit in bit 0. The value appears on io_rdata one clock edge after the read is sampled.
- R4: A data-port write while the index latch does not hold 70h leaves the routing bit unchanged. A data-port read in that state returns FFh.
- R5: Every write to the index port overwrites the whole index latch. A read of the index port returns the latch contents.
- R6: With the routing bit at 0, cpu_intr and cpu_nmi equal pic_intr_in and nmi_in as sampled one edge earlier, and lapic_lint0 and lapic_lint1 are 0.
- R7: With the routing bit at 1, lapic_lint0 carries pic_intr_in and lapic_lint1 carries nmi_in, each delayed by one edge, and cpu_intr and cpu_nmi are 0.
- R8: A routing change written at clock edge k does not alter the steered outputs at edge k. The outputs switch to the new path at edge k+1.
- R9: Reads of any address other than the two ports return FFh. Writes to any other address change neither the routing bit nor the index latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_rd | input | 1 | Read strobe, sampled at the clock edge |
| io_rdata | output | 8 | Registered read data |
| pic_intr_in | input | 1 | Legacy controller interrupt request |
| nmi_in | input | 1 | Non-maskable interrupt line |
| cpu_intr | output | 1 | Processor interrupt pin (direct path) |
| cpu_nmi | output | 1 | Processor NMI pin (direct path) |
| lapic_lint0 | output | 1 | Local interrupt input 0 (routed path) |
| lapic_lint1 | output | 1 | Local interrupt input 1 (routed path) |

## Verification
The hardest case to reach from the ports is the one where a data write must be ignored. The bench has to show that a write of 1 made under each of the 255 wrong index codes leaves the routing unchanged, and the routing bit itself is not visible at any port. The bench therefore sweeps every index value. After each ignored write it holds pic_intr_in high and checks that the direct pin still carries it. The same sweep sets the steered inputs and reads back through the data port. Separately, the edge on which the routing switches is pinned down by sampling the outputs right after the write edge and again one edge later.

// File: rtl/irt_pkg.sv
package irt_pkg;
  parameter int unsigned IO_DW = 8;

  typedef struct packed {
    logic cpu_intr;
    logic cpu_nmi;
    logic lint0;
    logic lint1;
  } route_out_t;

  // steering of the two interrupt lines by the routing bit
  function automatic route_out_t steer(input logic mode, input logic intr, input logic nmi);
    route_out_t r;
    r.cpu_intr = ~mode & intr;
    r.cpu_nmi  = ~mode & nmi;
    r.lint0    =  mode & intr;
    r.lint1    =  mode & nmi;
    return r;
  endfunction

  // read-back value for one sampled read strobe
  function automatic logic [IO_DW-1:0] read_value(input logic hit_index, input logic hit_data,
                                                  input logic sel, input logic [IO_DW-1:0] idx,
                                                  input logic mode);
    logic [IO_DW-1:0] v;
    if (hit_index)            v = idx;
    else if (hit_data && sel) v = {{(IO_DW-1){1'b0}}, mode};
    else                      v = {IO_DW{1'b1}};
    return v;
  endfunction
endpackage

// File: rtl/irt_port_decode.sv
module irt_port_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_index,
  output logic              hit_data
);
  assign hit_index = (addr == INDEX_PORT);
  assign hit_data  = (addr == DATA_PORT);
endmodule

// File: rtl/irt_index_latch.sv
module irt_index_latch
  import irt_pkg::*;
#(
  parameter logic [IO_DW-1:0] SEL_CODE = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IO_DW-1:0] wdata,
  output logic [IO_DW-1:0] idx_q,
  output logic             sel_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (wr_en) idx_q <= wdata;
  end
  assign sel_hit = (idx_q == SEL_CODE);
endmodule

// File: rtl/irt_mode_reg.sv
module irt_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wbit,
  output logic mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= 1'b0;
    else if (wr_en) mode_q <= wbit;
  end
endmodule

// File: rtl/irt_steer.sv
module irt_steer
  import irt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       intr,
  input  logic       nmi,
  output route_out_t out_q
);
  route_out_t nxt;
  assign nxt = steer(mode, intr, nmi);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt;
  end
endmodule

// File: rtl/intr_route_ctl.sv
module intr_route_ctl
  import irt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023,
  parameter logic [IO_DW-1:0]  SEL_CODE   = 8'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [IO_DW-1:0]  io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [IO_DW-1:0]  io_rdata,
  input  logic              pic_intr_in,
  input  logic              nmi_in,
  output logic              cpu_intr,
  output logic              cpu_nmi,
  output logic              lapic_lint0,
  output logic              lapic_lint1
);
  // named internal events, also used by the checker
  logic             hit_index, hit_data;
  logic             idx_wr, mode_wr, sel_hit;
  logic [IO_DW-1:0] idx_q;
  logic             mode_q;
  route_out_t       route_q;

  irt_port_decode #(.ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .addr(io_addr), .hit_index(hit_index), .hit_data(hit_data));

  assign idx_wr  = io_wr & hit_index;
  assign mode_wr = io_wr & hit_data & sel_hit;

  irt_index_latch #(.SEL_CODE(SEL_CODE)) u_idx (
    .clk(clk), .rst_n(rst_n), .wr_en(idx_wr), .wdata(io_wdata),
    .idx_q(idx_q), .sel_hit(sel_hit));

  irt_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr), .wbit(io_wdata[0]), .mode_q(mode_q));

  irt_steer u_steer (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .intr(pic_intr_in), .nmi(nmi_in),
    .out_q(route_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_rdata <= {IO_DW{1'b1}};
    else if (io_rd) io_rdata <= read_value(hit_index, hit_data, sel_hit, idx_q, mode_q);
  end

  assign cpu_intr    = route_q.cpu_intr;
  assign cpu_nmi     = route_q.cpu_nmi;
  assign lapic_lint0 = route_q.lint0;
  assign lapic_lint1 = route_q.lint1;
endmodule

// File: rtl/intr_route_ctl_chk.sv
module intr_route_ctl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023,
  parameter logic [7:0]        SEL_CODE   = 8'h70
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              pic_intr_in,
  input logic              nmi_in,
  input logic              cpu_intr,
  input logic              cpu_nmi,
  input logic              lapic_lint0,
  input logic              lapic_lint1,
  input logic              mode_q,
  input logic [7:0]        idx_q
);
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_state_r1: assert (mode_q == 1'b0 && idx_q == 8'h00);
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DATA_PORT && idx_q == SEL_CODE) |=> (mode_q == $past(io_wdata[0])));

  p_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == DATA_PORT && idx_q == SEL_CODE) |=> (io_rdata == {7'b0, $past(mode_q)}));

  p_ignore_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DATA_PORT && idx_q != SEL_CODE) |=> $stable(mode_q));

  p_ignore_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == DATA_PORT && idx_q != SEL_CODE) |=> (io_rdata == 8'hFF));

  p_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == INDEX_PORT) |=> (idx_q == $past(io_wdata)));

  p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q) |=> (cpu_intr == $past(pic_intr_in) && cpu_nmi == $past(nmi_in)
                   && !lapic_lint0 && !lapic_lint1));

  p_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q) |=> (lapic_lint0 == $past(pic_intr_in) && lapic_lint1 == $past(nmi_in)
                  && !cpu_intr && !cpu_nmi));

  p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != DATA_PORT && io_addr != INDEX_PORT) |=> ($stable(mode_q) && $stable(idx_q)));
endmodule

bind intr_route_ctl intr_route_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .pic_intr_in(pic_intr_in), .nmi_in(nmi_in),
  .cpu_intr(cpu_intr), .cpu_nmi(cpu_nmi), .lapic_lint0(lapic_lint0),
  .lapic_lint1(lapic_lint1), .mode_q(mode_q), .idx_q(idx_q));

// File: tb/intr_route_ctl_test.sv
`timescale 1ns/1ps
module intr_route_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        pic_intr_in = 1'b0, nmi_in = 1'b0;
  logic        cpu_intr, cpu_nmi, lapic_lint0, lapic_lint1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intr_route_ctl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .pic_intr_in(pic_intr_in), .nmi_in(nmi_in),
    .cpu_intr(cpu_intr), .cpu_nmi(cpu_nmi), .lapic_lint0(lapic_lint0),
    .lapic_lint1(lapic_lint1));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // steered outputs packed as {cpu_intr, cpu_nmi, lint0, lint1}
  function automatic logic [7:0] outs();
    return {4'b0, cpu_intr, cpu_nmi, lapic_lint0, lapic_lint1};
  endfunction

  function automatic logic [7:0] exp_outs(input logic m, input logic i, input logic n);
    return m ? {6'b0, i, n} : {4'b0, i, n, 2'b0};
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rd;
    logic       mode;
    repeat (3) @(negedge clk);
    check("R1 outputs at reset", outs(), 8'h00);
    rst_n = 1'b1;
    io_read(16'h0022, rd); check("R1 index after reset", rd, 8'h00);
    io_read(16'h0023, rd); check("R1 data unselected after reset", rd, 8'hFF);
    check("R1 outputs after reset", outs(), 8'h00);

    // R4 sweep: every index except 70h ignores a data write of FFh
    for (int ix = 0; ix < 256; ix++) begin
      if (ix != 8'h70) begin
        io_write(16'h0022, 8'(ix));
        io_write(16'h0023, 8'hFF);
        io_read(16'h0023, rd); check("R4 read unselected", rd, 8'hFF);
        io_read(16'h0022, rd); check("R5 index readback", rd, 8'(ix));
        pic_intr_in = 1'b1; nmi_in = 1'b1;
        @(negedge clk);
        check("R4 routing unchanged", outs(), exp_outs(1'b0, 1'b1, 1'b1));
        pic_intr_in = 1'b0; nmi_in = 1'b0;
      end
    end

    // R2/R3 sweep: every data byte under the select code
    io_write(16'h0022, 8'h70);
    for (int d = 0; d < 256; d++) begin
      io_write(16'h0023, 8'(d));
      io_read(16'h0023, rd); check("R3 readback bit0 only", rd, {7'b0, d[0]});
      for (int k = 0; k < 4; k++) begin
        pic_intr_in = k[1]; nmi_in = k[0];
        @(negedge clk);
        check(d[0] ? "R7 routed path" : "R6 direct path", outs(), exp_outs(d[0], k[1], k[0]));
      end
      pic_intr_in = 1'b0; nmi_in = 1'b0;
    end
    mode = 1'b1; // last byte FFh

    // R9: other addresses
    io_write(16'h0024, 8'h00);
    io_write(16'h0021, 8'h00);
    io_read(16'h0023, rd); check("R9 other-address write ignored (mode)", rd, {7'b0, mode});
    io_read(16'h0022, rd); check("R9 other-address write ignored (index)", rd, 8'h70);
    io_read(16'h0080, rd); check("R9 other-address read", rd, 8'hFF);

    // R8: switch timing, intr held high
    pic_intr_in = 1'b1;
    @(negedge clk);
    check("R8 before switch", outs(), exp_outs(1'b1, 1'b1, 1'b0));
    io_write(16'h0023, 8'h00);     // write edge k, now just after k
    check("R8 unchanged at write edge", outs(), exp_outs(1'b1, 1'b1, 1'b0));
    @(negedge clk);                // after edge k+1
    check("R8 switched next edge", outs(), exp_outs(1'b0, 1'b1, 1'b0));
    io_write(16'h0023, 8'h01);
    check("R8 unchanged at write edge back", outs(), exp_outs(1'b0, 1'b1, 1'b0));
    @(negedge clk);
    check("R8 switched back next edge", outs(), exp_outs(1'b1, 1'b1, 1'b0));

    // R5: leaving the selection disables data access
    io_write(16'h0022, 8'h71);
    io_write(16'h0023, 8'h00);
    io_write(16'h0022, 8'h70);
    io_read(16'h0023, rd); check("R5 reselect keeps mode", rd, 8'h01);

    // R1: reset mid-run restores defaults
    pic_intr_in = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    io_read(16'h0022, rd); check("R1 index cleared by reset", rd, 8'h00);
    io_write(16'h0022, 8'h70);
    io_read(16'h0023, rd); check("R1 mode cleared by reset", rd, 8'h00);

    finish_up();
  end
endmodule